// File: doc/BRIEF.md
# Single-Wire Pulse-Width Code Receiver

This block receives a brightness code over one line that idles high and is pulled low by an open-drain driver. Each symbol is one low pulse, and the block tells symbols apart only by how long the pulse lasts. A short pulse is a one. A pulse of middle length is a zero. A very long pulse tells the block to publish the bits it has collected. No clock travels with the data and no frame delimiter is used.

The line first passes through a synchroniser. A free-running divider then turns the system clock into a one-microsecond tick. Pulse lengths are counted in whole ticks. A high interval that is too short to be a real gap counts as a glitch, and the pulse on either side of it is treated as one pulse. Decoded bits shift into a code-wide register. A load command copies that register to the brightness output and raises a strobe for a single cycle.

A low enable or a raised undervoltage flag clears the shift register and the brightness output. The output then stays at code 0 until a new load arrives. Downstream logic maps the code linearly onto 32 analog levels.

Top module: `pwcode_rx`

## Requirements
- R1: After reset the brightness output is 0 and the update strobe is low. The idle line level is high.
- R2: A low pulse of 15 to 45 µs inclusive shifts a logic 1 into the shift register.
- R3: A low pulse of 90 to 120 µs inclusive shifts a logic 0 into the shift register.
- R4: A low pulse longer than 215 µs copies the shift register into the brightness output. The brightness output changes only on such a load or on a clear.
- R5: Bits enter at bit 0 and move toward bit 4, so the bit sent first ends up most significant. The sequence 1,0,1,0,0 followed by a load gives code 5'b10100.
- R6: A low pulse under 15 µs, from 46 to 89 µs, or from 121 to 215 µs leaves the shift register unchanged.
- R7: A high interval shorter than 3 µs inside a low pulse is a glitch. The low parts on both sides add up to a single pulse, and the glitch's own duration is not counted.
- R8: While enable is low or the undervoltage flag is high, the shift register and the brightness output are both held at 0. Afterwards a load with no new bits yields 0.
- R9: The update strobe is high for exactly one clock cycle per load command, even when fewer than five bits came before it. Positions not refilled keep their earlier bits.
- R10: The line input passes through a two-flop synchroniser. Pulse lengths are counted using a tick that occurs once every CLK_PER_US clocks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| en_i | input | 1 | Enable. Low clears the receiver |
| uv_i | input | 1 | Undervoltage flag. High clears the receiver |
| line_i | input | 1 | Single-wire line. Idles high |
| level_o | output | CODE_W | Brightness code |
| load_stb_o | output | 1 | One-cycle strobe on each load |

## Verification
A symbol is decoded only after the line has stayed high for the full 3 µs gap. The new code and the strobe then appear a few clocks after that: two synchroniser stages, up to one tick of gap quantisation, one symbol register and one output register. The bench therefore holds the line high for at least 8 µs after each pulse before it samples the output or the strobe count, and it samples on the falling clock edge. Pulse lengths stay at least 2 µs away from every window edge, which absorbs the one-tick uncertainty in the count. The strobe-width check runs every cycle, so a strobe that lasts two cycles is caught in the cycle where it happens.

// File: rtl/swr_pkg.sv
package swr_pkg;
   typedef enum logic [1:0] {
      SYM_NONE = 2'd0,
      SYM_ONE  = 2'd1,
      SYM_ZERO = 2'd2,
      SYM_LOAD = 2'd3
   } sym_t;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_LOW  = 2'd1,
      ST_GAP  = 2'd2
   } meas_st_t;
endpackage

// File: rtl/swr_sync.sv
module swr_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic q_o
);
   logic [STAGES-1:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '1;
      else        chain_q <= {chain_q[STAGES-2:0], d_i};
   end

   assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/swr_tick.sv
module swr_tick #(
   parameter int CLK_PER_US = 100
) (
   input  logic clk,
   input  logic rst_n,
   output logic tick_o
);
   generate
      if (CLK_PER_US == 1) begin : g_direct
         logic on_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) on_q <= 1'b0;
            else        on_q <= 1'b1;
         end
         assign tick_o = on_q;
      end else begin : g_div
         localparam int DIV_W = $clog2(CLK_PER_US);
         localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(CLK_PER_US - 1);
         logic [DIV_W-1:0] div_q;
         logic             tick_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               div_q  <= '0;
               tick_q <= 1'b0;
            end else begin
               tick_q <= (div_q == DIV_LAST);
               div_q  <= (div_q == DIV_LAST) ? '0 : div_q + 1'b1;
            end
         end
         assign tick_o = tick_q;

         // R10: ticks are spaced by the divider, never back to back
         p_tick_spaced_r10: assert property (@(posedge clk) disable iff (!rst_n)
            tick_o |=> !tick_o);
      end
   endgenerate
endmodule

// File: rtl/swr_pulse_meas.sv
module swr_pulse_meas #(
   parameter int ONE_MIN  = 15,
   parameter int ONE_MAX  = 45,
   parameter int ZERO_MIN = 90,
   parameter int ZERO_MAX = 120,
   parameter int LOAD_MIN = 215,
   parameter int GAP_MIN  = 3
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            clr_i,
   input  logic            tick_i,
   input  logic            line_i,
   output logic            sym_v_o,
   output swr_pkg::sym_t   sym_k_o
);
   import swr_pkg::*;

   localparam int LOW_W = $clog2(LOAD_MIN + 2);
   localparam int GAP_W = $clog2(GAP_MIN + 1);
   localparam logic [LOW_W-1:0] LOW_SAT = LOW_W'(LOAD_MIN + 1);
   localparam logic [LOW_W-1:0] L1_LO   = LOW_W'(ONE_MIN);
   localparam logic [LOW_W-1:0] L1_HI   = LOW_W'(ONE_MAX);
   localparam logic [LOW_W-1:0] L0_LO   = LOW_W'(ZERO_MIN);
   localparam logic [LOW_W-1:0] L0_HI   = LOW_W'(ZERO_MAX);
   localparam logic [LOW_W-1:0] LD_TH   = LOW_W'(LOAD_MIN);
   localparam logic [GAP_W-1:0] GAP_END = GAP_W'(GAP_MIN);

   meas_st_t         st_q;
   logic [LOW_W-1:0] low_q;
   logic [GAP_W-1:0] gap_q;
   sym_t             kind_c;

   function automatic sym_t classify(input logic [LOW_W-1:0] n);
      if (n > LD_TH)                      return SYM_LOAD;
      else if (n >= L0_LO && n <= L0_HI)  return SYM_ZERO;
      else if (n >= L1_LO && n <= L1_HI)  return SYM_ONE;
      else                                return SYM_NONE;
   endfunction

   assign kind_c = classify(low_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= ST_IDLE;
         low_q   <= '0;
         gap_q   <= '0;
         sym_v_o <= 1'b0;
         sym_k_o <= SYM_NONE;
      end else if (clr_i) begin
         st_q    <= ST_IDLE;
         low_q   <= '0;
         gap_q   <= '0;
         sym_v_o <= 1'b0;
         sym_k_o <= SYM_NONE;
      end else begin
         sym_v_o <= 1'b0;
         case (st_q)
            ST_IDLE: begin
               if (!line_i) begin
                  st_q  <= ST_LOW;
                  low_q <= '0;
               end
            end
            ST_LOW: begin
               if (line_i) begin
                  st_q  <= ST_GAP;
                  gap_q <= '0;
               end else if (tick_i && low_q != LOW_SAT) begin
                  low_q <= low_q + 1'b1;
               end
            end
            ST_GAP: begin
               if (!line_i) begin
                  st_q <= ST_LOW;                 // glitch: merge
               end else if (gap_q == GAP_END) begin
                  st_q    <= ST_IDLE;
                  sym_v_o <= (kind_c != SYM_NONE);
                  sym_k_o <= kind_c;
               end else if (tick_i) begin
                  gap_q <= gap_q + 1'b1;
               end
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   // R7: a symbol is only issued once a full high gap has been seen
   p_sym_after_gap_r7: assert property (@(posedge clk) disable iff (!rst_n)
      sym_v_o |-> ($past(st_q) == ST_GAP && $past(line_i)));

   // R6: a discarded pulse never leaves a valid symbol behind
   p_no_empty_sym_r6: assert property (@(posedge clk) disable iff (!rst_n)
      sym_v_o |-> sym_k_o != SYM_NONE);
endmodule

// File: rtl/swr_shift_load.sv
module swr_shift_load #(
   parameter int CODE_W = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr_i,
   input  logic              sym_v_i,
   input  swr_pkg::sym_t     sym_k_i,
   output logic [CODE_W-1:0] level_o,
   output logic              stb_o
);
   import swr_pkg::*;

   logic [CODE_W-1:0] sreg_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sreg_q  <= '0;
         level_o <= '0;
         stb_o   <= 1'b0;
      end else if (clr_i) begin
         sreg_q  <= '0;
         level_o <= '0;
         stb_o   <= 1'b0;
      end else begin
         stb_o <= 1'b0;
         if (sym_v_i) begin
            case (sym_k_i)
               SYM_ONE:  sreg_q <= {sreg_q[CODE_W-2:0], 1'b1};
               SYM_ZERO: sreg_q <= {sreg_q[CODE_W-2:0], 1'b0};
               SYM_LOAD: begin
                  level_o <= sreg_q;
                  stb_o   <= 1'b1;
               end
               default: ;
            endcase
         end
      end
   end

   // R9: the strobe never lasts more than one cycle
   p_stb_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
      stb_o |=> !stb_o);

   // R4: the output moves only with a strobe or after a clear
   p_level_moves_on_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (level_o != $past(level_o)) |-> (stb_o || $past(clr_i)));

   // R8: a clear empties both registers on the next cycle
   p_clear_empties_r8: assert property (@(posedge clk) disable iff (!rst_n)
      clr_i |=> (level_o == '0 && sreg_q == '0 && !stb_o));

   // R5: a decoded one lands in bit 0
   p_one_enters_lsb_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (sym_v_i && sym_k_i == SYM_ONE && !clr_i) |=> sreg_q[0]);
endmodule

// File: rtl/pwcode_rx.sv
module pwcode_rx #(
   parameter int CLK_PER_US  = 100,
   parameter int CODE_W      = 5,
   parameter int SYNC_STAGES = 2,
   parameter int ONE_MIN     = 15,
   parameter int ONE_MAX     = 45,
   parameter int ZERO_MIN    = 90,
   parameter int ZERO_MAX    = 120,
   parameter int LOAD_MIN    = 215,
   parameter int GAP_MIN     = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en_i,
   input  logic              uv_i,
   input  logic              line_i,
   output logic [CODE_W-1:0] level_o,
   output logic              load_stb_o
);
   generate
      if (CLK_PER_US < 1) begin : g_chk_div
         $error("pwcode_rx: CLK_PER_US must be at least 1");
      end
      if (CODE_W < 2) begin : g_chk_w
         $error("pwcode_rx: CODE_W must be at least 2");
      end
      if (SYNC_STAGES < 2) begin : g_chk_sync
         $error("pwcode_rx: SYNC_STAGES must be at least 2");
      end
      if (!(ONE_MIN < ONE_MAX && ONE_MAX < ZERO_MIN &&
            ZERO_MIN < ZERO_MAX && ZERO_MAX < LOAD_MIN)) begin : g_chk_win
         $error("pwcode_rx: duration windows must be ordered and disjoint");
      end
      if (GAP_MIN < 1) begin : g_chk_gap
         $error("pwcode_rx: GAP_MIN must be at least 1");
      end
   endgenerate

   logic          line_s;
   logic          tick;
   logic          clr;
   logic          sym_v;
   swr_pkg::sym_t sym_k;

   assign clr = !en_i || uv_i;

   swr_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (line_i),
      .q_o   (line_s)
   );

   swr_tick #(.CLK_PER_US(CLK_PER_US)) u_tick (
      .clk    (clk),
      .rst_n  (rst_n),
      .tick_o (tick)
   );

   swr_pulse_meas #(
      .ONE_MIN  (ONE_MIN),
      .ONE_MAX  (ONE_MAX),
      .ZERO_MIN (ZERO_MIN),
      .ZERO_MAX (ZERO_MAX),
      .LOAD_MIN (LOAD_MIN),
      .GAP_MIN  (GAP_MIN)
   ) u_meas (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr_i   (clr),
      .tick_i  (tick),
      .line_i  (line_s),
      .sym_v_o (sym_v),
      .sym_k_o (sym_k)
   );

   swr_shift_load #(.CODE_W(CODE_W)) u_shift (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr_i   (clr),
      .sym_v_i (sym_v),
      .sym_k_i (sym_k),
      .level_o (level_o),
      .stb_o   (load_stb_o)
   );

   // R1: no strobe in the first cycle after reset
   p_quiet_after_reset_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (!load_stb_o && level_o == '0));
endmodule

// File: tb/pwcode_rx_tb_top.sv
module pwcode_rx_tb_top;
   localparam int CPU = 4;
   localparam int WD  = 190000;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       en = 1'b1;
   logic       uv = 1'b0;
   logic       line = 1'b1;
   logic [4:0] level;
   logic       stb;

   int tests = 0;
   int fails = 0;
   int stb_cnt = 0;
   int exp_loads = 0;
   logic [4:0] exp_sreg = '0;
   logic [4:0] exp_level = '0;
   logic stb_prev = 1'b0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   pwcode_rx #(.CLK_PER_US(CPU)) dut_i (
      .clk(clk), .rst_n(rst_n), .en_i(en), .uv_i(uv), .line_i(line),
      .level_o(level), .load_stb_o(stb)
   );

   // R9: count strobes and flag any that last two cycles
   always @(negedge clk) begin
      if (rst_n && stb) begin
         stb_cnt = stb_cnt + 1;
         if (stb_prev) begin
            tests = tests + 1;
            fails = fails + 1;
            $display("FAIL R9 strobe width actual=2+ expected=1");
         end
      end
      stb_prev = stb;
   end

   task automatic chk(input string req, input int act, input int exp);
      tests++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic wait_us(input int n);
      repeat (n * CPU) @(negedge clk);
   endtask

   // 0 none, 1 one, 2 zero, 3 load
   function automatic int cls(input int us);
      if (us > 215)                return 3;
      if (us >= 90 && us <= 120)   return 2;
      if (us >= 15 && us <= 45)    return 1;
      return 0;
   endfunction

   function automatic void model(input int k);
      if (k == 1) exp_sreg = {exp_sreg[3:0], 1'b1};
      else if (k == 2) exp_sreg = {exp_sreg[3:0], 1'b0};
      else if (k == 3) begin
         exp_level = exp_sreg;
         exp_loads++;
      end
   endfunction

   task automatic pulse(input int lo);
      line = 1'b0; wait_us(lo);
      line = 1'b1; wait_us(8);
      model(cls(lo));
   endtask

   task automatic glitch_pulse(input int a, input int b);
      line = 1'b0; wait_us(a);
      line = 1'b1; wait_us(1);
      line = 1'b0; wait_us(b);
      line = 1'b1; wait_us(8);
      model(cls(a + b));
   endtask

   task automatic check_load(input string req);
      chk({req, " level"}, int'(level), int'(exp_level));
      chk({req, " strobes"}, stb_cnt, exp_loads);
   endtask

   function automatic int pick_bad();
      int r = int'($urandom_range(0, 2));
      if (r == 0) return int'($urandom_range(3, 12));
      if (r == 1) return int'($urandom_range(48, 87));
      return int'($urandom_range(123, 212));
   endfunction

   initial begin
      repeat (WD) @(posedge clk);
      if (!done) begin
         tests++;
         fails++;
         $display("FAIL R10 watchdog actual=hung expected=done");
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd2024));
      repeat (10) @(negedge clk);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);
      chk("R1 reset level", int'(level), 0);
      chk("R1 reset strobe", int'(stb), 0);

      // R5: 1,0,1,0,0 then load gives 10100
      pulse(30); pulse(100); pulse(30); pulse(100); pulse(100);
      chk("R4 no change before load", int'(level), 0);
      pulse(250);
      check_load("R5");
      chk("R5 code 10100", int'(level), 20);

      // R9: partial load, two new bits
      pulse(25); pulse(35); pulse(240);
      check_load("R9 partial");

      // R6: out-of-window pulses ignored
      pulse(8); pulse(60); pulse(160); pulse(230);
      check_load("R6 ignored");

      // R2 and R3 near window edges
      pulse(17); pulse(43); pulse(92); pulse(118); pulse(33); pulse(218);
      check_load("R2 R3 edges");

      // R7: glitches merge pulses
      glitch_pulse(12, 12); glitch_pulse(50, 50); glitch_pulse(20, 5);
      glitch_pulse(130, 120);
      check_load("R7 glitch");

      // R8: enable low clears
      en = 1'b0; wait_us(5);
      chk("R8 en clear", int'(level), 0);
      en = 1'b1; exp_sreg = '0; exp_level = '0;
      wait_us(5);
      chk("R8 still 0", int'(level), 0);
      pulse(250);
      check_load("R8 empty load");
      pulse(30); pulse(30); pulse(250);
      check_load("R8 after reload");
      uv = 1'b1; wait_us(5);
      chk("R8 uv clear", int'(level), 0);
      uv = 1'b0; exp_sreg = '0; exp_level = '0;
      pulse(250);
      check_load("R8 uv empty load");

      // random frames
      for (int f = 0; f < 30; f++) begin
         int nb = int'($urandom_range(0, 7));
         for (int b = 0; b < nb; b++) begin
            int sel = int'($urandom_range(0, 9));
            if (sel < 4)       pulse(int'($urandom_range(17, 43)));
            else if (sel < 8)  pulse(int'($urandom_range(92, 118)));
            else if (sel == 8) pulse(pick_bad());
            else               glitch_pulse(int'($urandom_range(8, 12)),
                                            int'($urandom_range(8, 20)));
         end
         chk("R4 held before load", int'(level), int'(exp_level));
         pulse(int'($urandom_range(218, 260)));
         check_load("R4 R9 random");
      end

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule